// File: doc/BRIEF.md
# Fractional Virtual Channel Rate Throttle

This block sets, for each of four streams sharing a link, how many time slots each stream gets in every frame. A stream's average rate is given as an integer slot count X and a fraction Y. Y is the fractional part of the average scaled by 2^25 and rounded up, so a nonzero fraction never becomes zero. Each stream keeps a 25-bit accumulator. On every frame the accumulator adds Y. The stream's budget for that frame is X, plus one extra slot when the addition carries out of the top accumulator bit.

Software writes a new rate through a small configuration port by giving a stream index with X and Y. The write lands in a shadow copy and raises a per-stream pending flag. The rate in use changes only at the next frame boundary, where the flag drops and the accumulator starts over. The block hands the per-frame budgets to the slot placement logic, which is a separate block.

Top module: `vc_rate_throttle`

## Requirements
- R1: After reset every budget is 0, budget_valid is 0, all pending flags are 0 and idx_err is 0.
- R2: A write (cfg_wr high) with cfg_idx below 4 stores cfg_x and cfg_y as the shadow rate of stream cfg_idx, and that stream's bit of rate_pending is 1 from the following cycle on. Other streams are not affected.
- R3: budget_valid is 1 exactly in the cycle after a frame_tick cycle. Budgets change only in that cycle and otherwise hold their value.
- R4: At a frame_tick, a stream with no pending update adds its Y to its 25-bit accumulator and keeps the low 25 bits. Its budget becomes X plus the carry out of bit 24.
- R5: At a frame_tick, a stream with a pending update installs its shadow rate, clears its accumulator and then adds the new Y to it. Its budget for that frame is the new X, and its pending bit clears.
- R6: When a write and a frame_tick arrive in the same cycle, the tick uses the rate stored before the write. The written rate stays pending until the next tick.
- R7: A write with cfg_idx of 4 or more changes no stream and sets idx_err, which stays 1 until reset.
- R8: Over n frames counted from the frame that installs a rate, a stream's total budget is n*X + floor(n*Y/2^25). Over 2^25 frames this is exactly X*2^25 + Y.
- R9: Budget field of stream s sits at budget[s*9 +: 9] (9 bits, zero-extended X plus carry); rate_pending bit s belongs to stream s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Rate write strobe |
| cfg_idx | input | 3 | Stream index of the write |
| cfg_x | input | 8 | Integer slots per frame |
| cfg_y | input | 25 | Fraction of a slot per frame, scaled by 2^25 |
| frame_tick | input | 1 | Frame boundary pulse |
| budget_valid | output | 1 | Budgets updated for the new frame |
| budget | output | 36 | Four 9-bit per-stream slot budgets |
| rate_pending | output | 4 | Per-stream rate update waiting for a frame boundary |
| idx_err | output | 1 | Sticky: a write named a stream that does not exist |

## Verification
The random phase mixes writes to all indices, including invalid ones, with frame ticks at irregular spacing. It often lands a write in the same cycle as a tick, which shows whether the write or the tick wins (R6). Two long directed runs use Y = 2^25-1 and Y = 2^24. The first carries on nearly every frame and the second on every other frame, so the summed budgets show any drift in carry counting or any wrong accumulator clear at install (R8). Directed writes to an out-of-range index, followed by reads of the unchanged budgets and pending flags, show the write being ignored and the error bit staying set.

// File: rtl/vc_rate_throttle.sv
module vc_rate_throttle #(
  parameter int NUM_STREAMS = 4,
  parameter int INT_W       = 8,
  parameter int FRAC_W      = 25,
  parameter int IDX_W       = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_wr,
  input  logic [IDX_W-1:0]                   cfg_idx,
  input  logic [INT_W-1:0]                   cfg_x,
  input  logic [FRAC_W-1:0]                  cfg_y,
  input  logic                               frame_tick,
  output logic                               budget_valid,
  output logic [NUM_STREAMS*(INT_W+1)-1:0]   budget,
  output logic [NUM_STREAMS-1:0]             rate_pending,
  output logic                               idx_err
);
  localparam int BUD_W = INT_W + 1;
  localparam logic [IDX_W:0] NS = NUM_STREAMS[IDX_W:0];

  wire bad_idx = cfg_wr && ({1'b0, cfg_idx} >= NS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      budget_valid <= 1'b0;
      idx_err      <= 1'b0;
    end else begin
      budget_valid <= frame_tick;
      if (bad_idx) idx_err <= 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    localparam logic [IDX_W-1:0] SEL = s[IDX_W-1:0];
    logic [INT_W-1:0]  sh_x, ac_x;
    logic [FRAC_W-1:0] sh_y, ac_y, acc;
    logic [BUD_W-1:0]  bud;
    logic              pend;

    wire              hit = cfg_wr && (cfg_idx == SEL);
    wire [FRAC_W:0]   sum = {1'b0, acc} + {1'b0, ac_y};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_x <= '0; sh_y <= '0; ac_x <= '0; ac_y <= '0;
        acc  <= '0; bud  <= '0; pend <= 1'b0;
      end else begin
        if (hit) begin
          sh_x <= cfg_x;
          sh_y <= cfg_y;
        end
        if (frame_tick) begin
          if (pend) begin
            ac_x <= sh_x;
            ac_y <= sh_y;
            acc  <= sh_y;
            bud  <= {1'b0, sh_x};
          end else begin
            acc  <= sum[FRAC_W-1:0];
            bud  <= {1'b0, ac_x} + {{INT_W{1'b0}}, sum[FRAC_W]};
          end
        end
        if (hit) pend <= 1'b1;
        else if (frame_tick) pend <= 1'b0;
      end
    end

    assign budget[s*BUD_W +: BUD_W] = bud;
    assign rate_pending[s] = pend;
  end
endmodule

// File: rtl/vc_rate_throttle_chk.sv
module vc_rate_throttle_chk #(
  parameter int NUM_STREAMS = 4,
  parameter int INT_W       = 8,
  parameter int FRAC_W      = 25,
  parameter int IDX_W       = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             cfg_wr,
  input logic [IDX_W-1:0]                 cfg_idx,
  input logic                             frame_tick,
  input logic                             budget_valid,
  input logic [NUM_STREAMS*(INT_W+1)-1:0] budget,
  input logic [NUM_STREAMS-1:0]           rate_pending,
  input logic                             idx_err
);
  localparam logic [IDX_W:0] NS = NUM_STREAMS[IDX_W:0];

  a_r2_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && ({1'b0, cfg_idx} < NS) |=> ((rate_pending >> $past(cfg_idx)) & 1) != 0);

  a_r3_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> budget_valid);

  a_r3_no_valid_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> !budget_valid);

  a_r3_budget_held: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(budget));

  a_r5_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && !cfg_wr |=> rate_pending == '0);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |=> idx_err);
endmodule

bind vc_rate_throttle vc_rate_throttle_chk #(
  .NUM_STREAMS(NUM_STREAMS), .INT_W(INT_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
  .frame_tick(frame_tick), .budget_valid(budget_valid), .budget(budget),
  .rate_pending(rate_pending), .idx_err(idx_err)
);

// File: tb/vc_rate_throttle_test.sv
`timescale 1ns/1ps
module vc_rate_throttle_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [7:0]  cfg_x = '0;
  logic [24:0] cfg_y = '0;
  logic        frame_tick = 1'b0;
  logic        budget_valid;
  logic [35:0] budget;
  logic [3:0]  rate_pending;
  logic        idx_err;

  int checks = 0;
  int fails  = 0;

  longint m_sx[4], m_sy[4], m_ax[4], m_ay[4], m_acc[4], m_bud[4];
  bit     m_pend[4];
  bit     m_err;

  always #2 clk = ~clk;

  vc_rate_throttle uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_x(cfg_x), .cfg_y(cfg_y), .frame_tick(frame_tick),
    .budget_valid(budget_valid), .budget(budget),
    .rate_pending(rate_pending), .idx_err(idx_err)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint dut_bud(int s);
    return longint'(budget[s*9 +: 9]);
  endfunction

  function automatic longint frame_total(longint n, longint x, longint y);
    return n * x + ((n * y) >> 25);
  endfunction

  task automatic compare_all(string tag);
    chk({tag, " R3 valid"}, longint'(budget_valid), 0);
    for (int s = 0; s < 4; s++) begin
      chk({tag, " R4 budget"}, dut_bud(s), m_bud[s]);
      chk({tag, " R2 pending"}, longint'(rate_pending[s]), longint'(m_pend[s]));
    end
    chk({tag, " R7 err"}, longint'(idx_err), longint'(m_err));
  endtask

  task automatic step(bit wr, int idx, int x, int y, bit tick);
    @(negedge clk);
    cfg_wr = wr; cfg_idx = idx[2:0]; cfg_x = x[7:0]; cfg_y = y[24:0]; frame_tick = tick;
    @(posedge clk);
    #1;
    for (int s = 0; s < 4; s++) begin
      if (tick) begin
        if (m_pend[s]) begin
          m_ax[s] = m_sx[s]; m_ay[s] = m_sy[s]; m_acc[s] = m_sy[s]; m_bud[s] = m_sx[s];
        end else begin
          longint sum = m_acc[s] + m_ay[s];
          m_bud[s] = m_ax[s] + (sum >> 25);
          m_acc[s] = sum & 64'h1FF_FFFF;
        end
      end
      if (wr && idx == s) begin
        m_sx[s] = x & 255; m_sy[s] = y & 32'h1FF_FFFF; m_pend[s] = 1'b1;
      end else if (tick) m_pend[s] = 1'b0;
    end
    if (wr && idx >= 4) m_err = 1'b1;
    checks++;
    if (budget_valid !== tick) begin
      fails++;
      $display("FAIL R3 valid actual=%0d expected=%0d", budget_valid, tick);
    end
    for (int s = 0; s < 4; s++) begin
      chk("R4/R5 budget", dut_bud(s), m_bud[s]);
      chk("R2 pending", longint'(rate_pending[s]), longint'(m_pend[s]));
    end
    chk("R7 idx_err", longint'(idx_err), longint'(m_err));
    cfg_wr = 1'b0; frame_tick = 1'b0;
  endtask

  task automatic long_run(int s, int x, int y, int n);
    longint total = 0;
    step(1, s, x, y, 0);
    for (int k = 0; k < n; k++) begin
      step(0, 0, 0, 0, 1);
      total += dut_bud(s);
    end
    chk("R8 long-run total", total, frame_total(n, x, y));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < 4; s++) begin
      m_sx[s] = 0; m_sy[s] = 0; m_ax[s] = 0; m_ay[s] = 0;
      m_acc[s] = 0; m_bud[s] = 0; m_pend[s] = 0;
    end
    m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    compare_all("R1 reset");

    // R2 / R9: write one stream, others untouched
    step(1, 2, 7, 25'h100_0000, 0);
    step(0, 0, 0, 0, 0);
    // R5: install at tick, budget = new X
    step(0, 0, 0, 0, 1);
    chk("R5 installed budget", dut_bud(2), 7);
    // R4: half fraction carries on second frame after install
    step(0, 0, 0, 0, 1);
    chk("R4 carry frame", dut_bud(2), 8);
    step(0, 0, 0, 0, 1);
    chk("R4 no-carry frame", dut_bud(2), 7);
    // R6: write and tick in one cycle
    step(1, 2, 20, 0, 1);
    chk("R6 tick uses old rate", dut_bud(2), 8);
    chk("R6 still pending", longint'(rate_pending[2]), 1);
    step(0, 0, 0, 0, 1);
    chk("R6 new rate next tick", dut_bud(2), 20);
    // R7: out-of-range index ignored
    step(1, 5, 99, 99, 0);
    chk("R7 err set", longint'(idx_err), 1);
    chk("R7 no pending", longint'(rate_pending), 0);
    step(1, 7, 1, 1, 1);
    chk("R7 budget untouched", dut_bud(2), 20);
    step(0, 0, 0, 0, 0);
    chk("R7 sticky", longint'(idx_err), 1);

    // R8: long runs
    long_run(0, 3, 25'h1FF_FFFF, 300);
    long_run(1, 5, 25'h100_0000, 300);
    long_run(3, 0, 1, 50);

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      bit wr = ($urandom % 3) == 0;
      int idx = ($urandom % 10 == 0) ? 4 + int'($urandom % 4) : int'($urandom % 4);
      int x = int'($urandom % 256);
      int y = ($urandom % 4 == 0) ? 25'h1FF_FFFF : int'($urandom & 32'h1FF_FFFF);
      bit tick = ($urandom % 3) == 0;
      step(wr, idx, x, y, tick);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule